// File: doc/BRIEF.md
# BFloat16 Widening Fused Multiply-Add

This block is a four-lane vector datapath. Each lane takes one 16-bit BFloat16 element from each of two 128-bit source vectors and widens both to single precision by appending sixteen zero bits below them. It multiplies the two and adds the exact product to the matching 32-bit lane of a 128-bit accumulator vector. There is only one rounding step, always round-to-nearest with ties to even. A select input chooses whether every lane uses the even-indexed (bottom) or the odd-indexed (top) 16-bit element of its 32-bit slot.

The result vector and a valid strobe appear one clock after an accepted request. Exception conditions from all lanes are ORed into a sticky flag register, and only an explicit clear input resets that register. The three 4-bit register-number fields of the request are checked for quad alignment. A request with an odd register number is rejected and reported, and it changes no state.

Top module: `bf16_fma_vec`

## Requirements
- R1: Lane e (e = 0..3) uses the 16-bit element at index 2*e + sel_top of each source vector, where element k occupies bits [16k+15:16k]; sel_top=0 selects even elements and sel_top=1 selects odd elements.
- R2: Each lane result equals the exact value acc + (a<<16)*(b<<16), with both sources read as FP32, rounded once to FP32 with round-to-nearest-even; inexact (flags[0]) is set when that rounding discards any nonzero bits.
- R3: A finite sum that cancels to exactly zero gives +0 (0x00000000) with no flag set.
- R4: Denormal inputs (exponent field zero) are read as signed zero. A nonzero result whose biased exponent before rounding is below 1 becomes a zero of the result's sign and sets underflow (flags[1]) without setting inexact.
- R5: Every NaN result is 0x7FC00000. Invalid (flags[3]) is set for a signalling NaN on any input, for infinity times zero, and for infinity plus infinity of opposite sign. A quiet NaN input gives the default NaN with no flag.
- R6: A finite result that rounds to a biased exponent of 255 or more becomes an infinity of the result's sign and sets overflow (flags[2]) and inexact (flags[0]). An infinite operand passes through as an exact infinity.
- R7: flags = {invalid, overflow, underflow, inexact} is sticky. It takes the OR of every lane of every accepted request, and its bits fall only when flag_clr is high, which zeroes it on the next edge and takes priority over a request in the same cycle.
- R8: When in_valid is high and bit 0 of rd_idx, rn_idx or rm_idx is 1, illegal is high on the next cycle, out_valid stays low, and result and flags keep their values.
- R9: After reset, result, flags, out_valid and illegal are zero. An accepted request drives out_valid high for exactly the next cycle with the new result, and result holds its value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| sel_top | input | 1 | 0: even (bottom) elements, 1: odd (top) elements |
| src_a | input | 128 | First source, eight BF16 elements |
| src_b | input | 128 | Second source, eight BF16 elements |
| acc_in | input | 128 | Accumulator, four FP32 lanes |
| rd_idx | input | 4 | Destination register number (must be even) |
| rn_idx | input | 4 | First source register number (must be even) |
| rm_idx | input | 4 | Second source register number (must be even) |
| flag_clr | input | 1 | Clears the sticky flags |
| out_valid | output | 1 | Result valid, one cycle after an accepted request |
| result | output | 128 | Four FP32 result lanes |
| flags | output | 4 | Sticky {invalid, overflow, underflow, inexact} |
| illegal | output | 1 | Previous request had an odd register number |

## Verification
The hardest cases to reach are an exact halfway tie in the final rounding and a sum that cancels exactly, because random vectors almost never produce them. The stimulus builds them on purpose. A product of 2^-24 is added to 1.0 and to 1.0 plus one ulp, which gives one tie that rounds down and one that rounds up. A product is added to its own negation to get exact cancellation. Further steered random requests set the accumulator's exponent equal to the product's exponent and flip its sign, so that wide partial cancellation is exercised. An exact wide-integer model in the bench checks each of these results.

// File: rtl/bfma_pkg.sv
package bfma_pkg;
  localparam int LANE_W = 32;
  localparam int ELEM_W = 16;
  localparam int FW     = 25;
  localparam int WW     = 2 * FW;
  localparam int SW     = WW + 1;
  localparam int ANCHOR = (FW - 2) + (WW - FW);
  localparam int FLAG_W = 4;
  localparam logic [31:0] QNAN_DEF = 32'h7FC0_0000;

  typedef struct packed {
    logic inv;
    logic ovf;
    logic unf;
    logic inx;
  } flag_t;
endpackage

// File: rtl/bfma_round.sv
module bfma_round
  import bfma_pkg::*;
(
  input  logic               sign_i,
  input  logic signed [11:0] eref_i,
  input  logic [SW-1:0]      mag_i,
  output logic [31:0]        r_o,
  output flag_t              fl_o
);
  logic [5:0]         msb;
  logic [SW-1:0]      norm;
  logic [23:0]        mant;
  logic               g, st, inc;
  logic [24:0]        mr;
  logic signed [11:0] e_res, e_fin;

  always_comb begin
    msb = '0;
    for (int i = 0; i < SW; i++)
      if (mag_i[i]) msb = 6'(i);
  end

  always_comb begin
    norm  = mag_i << (6'(SW - 1) - msb);
    mant  = norm[SW-1 -: 24];
    g     = norm[SW-25];
    st    = |norm[SW-26:0];
    inc   = g & (st | mant[0]);
    mr    = {1'b0, mant} + 25'(inc);
    e_res = eref_i + $signed({6'b0, msb}) - 12'sd48;
    e_fin = e_res + $signed({11'b0, mr[24]});
    fl_o  = '0;
    if (mag_i == '0) begin
      r_o = 32'h0;
    end else if (e_res < 12'sd1) begin
      r_o      = {sign_i, 31'h0};
      fl_o.unf = 1'b1;
    end else if (e_fin >= 12'sd255) begin
      r_o      = {sign_i, 8'hFF, 23'h0};
      fl_o.ovf = 1'b1;
      fl_o.inx = 1'b1;
    end else begin
      r_o      = {sign_i, e_fin[7:0], mr[24] ? 23'h0 : mr[22:0]};
      fl_o.inx = g | st;
    end
  end
endmodule

// File: rtl/bfma_lane.sv
module bfma_lane
  import bfma_pkg::*;
(
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  input  logic [LANE_W-1:0] c_i,
  output logic [LANE_W-1:0] r_o,
  output flag_t             fl_o
);
  logic [7:0]  ea, eb, ec;
  logic        a_zero, b_zero, c_zero, a_inf, b_inf, c_inf;
  logic        a_nan, b_nan, c_nan, any_snan, p_sign, p_zero, p_inf, inv;
  logic [15:0] prod;
  logic [FW-1:0] f_p, f_c, f_big, f_s;
  logic signed [11:0] e_p, e_c, e_big, e_s, d_e;
  logic        big_c, s_big, s_small, sub, neg;
  logic [6:0]  sh;
  logic [FW+WW-1:0] ext;
  logic [WW-1:0] x, y;
  logic [WW+1:0] diff;
  logic [SW-1:0] mag;
  logic [31:0]   r_fin;
  flag_t         fl_fin;

  assign ea = a_i[14:7];
  assign eb = b_i[14:7];
  assign ec = c_i[30:23];
  assign a_zero = (ea == 8'h00);
  assign b_zero = (eb == 8'h00);
  assign c_zero = (ec == 8'h00);
  assign a_inf  = (ea == 8'hFF) && (a_i[6:0] == '0);
  assign b_inf  = (eb == 8'hFF) && (b_i[6:0] == '0);
  assign c_inf  = (ec == 8'hFF) && (c_i[22:0] == '0);
  assign a_nan  = (ea == 8'hFF) && (a_i[6:0] != '0);
  assign b_nan  = (eb == 8'hFF) && (b_i[6:0] != '0);
  assign c_nan  = (ec == 8'hFF) && (c_i[22:0] != '0);
  assign any_snan = (a_nan & ~a_i[6]) | (b_nan & ~b_i[6]) | (c_nan & ~c_i[22]);
  assign p_sign = a_i[15] ^ b_i[15];
  assign p_zero = a_zero | b_zero;
  assign p_inf  = (a_inf | b_inf) & ~p_zero & ~a_nan & ~b_nan;
  assign inv    = any_snan | (a_inf & b_zero) | (b_inf & a_zero)
                | (p_inf & c_inf & (p_sign != c_i[31]));

  // exact significand product and alignment window
  assign prod  = {1'b1, a_i[6:0]} * {1'b1, b_i[6:0]};
  assign f_p   = {prod, 9'b0};
  assign f_c   = {2'b01, c_i[22:0]};
  assign e_p   = $signed({4'b0, ea}) + $signed({4'b0, eb}) - 12'sd127;
  assign e_c   = $signed({4'b0, ec});
  assign big_c = ~c_zero && (e_c > e_p);
  assign f_big = big_c ? f_c : f_p;
  assign f_s   = big_c ? f_p : (c_zero ? '0 : f_c);
  assign e_big = big_c ? e_c : e_p;
  assign e_s   = big_c ? e_p : e_c;
  assign s_big   = big_c ? c_i[31] : p_sign;
  assign s_small = big_c ? p_sign : c_i[31];
  assign d_e   = e_big - e_s;
  assign sh    = (d_e < 12'sd0) ? 7'd0 : (d_e > 12'sd50) ? 7'd50 : d_e[6:0];
  assign ext   = {f_s, {WW{1'b0}}} >> sh;
  assign x     = {f_big, {(WW-FW){1'b0}}};
  assign y     = ext[FW+WW-1:FW] | {{(WW-1){1'b0}}, |ext[FW-1:0]};
  assign sub   = s_big ^ s_small;
  assign diff  = sub ? ({2'b0, x} - {2'b0, y}) : ({2'b0, x} + {2'b0, y});
  assign neg   = sub & diff[WW+1];
  assign mag   = neg ? SW'(~diff + 1'b1) : diff[SW-1:0];

  bfma_round u_round (
    .sign_i (neg ? ~s_big : s_big),
    .eref_i (e_big),
    .mag_i  (mag),
    .r_o    (r_fin),
    .fl_o   (fl_fin)
  );

  always_comb begin
    fl_o = '0;
    if (a_nan | b_nan | c_nan | inv) begin
      r_o      = QNAN_DEF;
      fl_o.inv = inv;
    end else if (p_inf) begin
      r_o = {p_sign, 8'hFF, 23'h0};
    end else if (c_inf) begin
      r_o = c_i;
    end else if (p_zero & c_zero) begin
      r_o = {p_sign & c_i[31], 31'h0};
    end else if (p_zero) begin
      r_o = c_i;
    end else begin
      r_o  = r_fin;
      fl_o = fl_fin;
    end
  end
endmodule

// File: rtl/bf16_fma_vec.sv
module bf16_fma_vec
  import bfma_pkg::*;
#(
  parameter int LANES = 4,
  parameter int REG_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    sel_top,
  input  logic [LANES*LANE_W-1:0] src_a,
  input  logic [LANES*LANE_W-1:0] src_b,
  input  logic [LANES*LANE_W-1:0] acc_in,
  input  logic [REG_W-1:0]        rd_idx,
  input  logic [REG_W-1:0]        rn_idx,
  input  logic [REG_W-1:0]        rm_idx,
  input  logic                    flag_clr,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] result,
  output logic [FLAG_W-1:0]       flags,
  output logic                    illegal
);
  localparam int VEC_W = LANES * LANE_W;

  logic [VEC_W-1:0] lane_r;
  flag_t            lane_fl [LANES];
  flag_t            fl_any;
  logic             legal, accept;

  assign legal  = ~(rd_idx[0] | rn_idx[0] | rm_idx[0]);
  assign accept = in_valid & legal;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    bfma_lane u_lane (
      .a_i  (src_a[(2*e)*ELEM_W + (sel_top ? ELEM_W : 0) +: ELEM_W]),
      .b_i  (src_b[(2*e)*ELEM_W + (sel_top ? ELEM_W : 0) +: ELEM_W]),
      .c_i  (acc_in[e*LANE_W +: LANE_W]),
      .r_o  (lane_r[e*LANE_W +: LANE_W]),
      .fl_o (lane_fl[e])
    );
  end

  always_comb begin
    fl_any = '0;
    for (int e = 0; e < LANES; e++) fl_any = fl_any | lane_fl[e];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags     <= '0;
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= accept;
      illegal   <= in_valid & ~legal;
      if (accept) result <= lane_r;
      if (flag_clr)    flags <= '0;
      else if (accept) flags <= flags | fl_any;
    end
  end
endmodule

// File: rtl/bfma_checker.sv
module bfma_checker #(
  parameter int VEC_W = 128,
  parameter int REG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [REG_W-1:0] rd_idx,
  input logic [REG_W-1:0] rn_idx,
  input logic [REG_W-1:0] rm_idx,
  input logic             flag_clr,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic [3:0]       flags,
  input logic             illegal
);
  logic odd_req;
  assign odd_req = rd_idx[0] | rn_idx[0] | rm_idx[0];

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && !odd_req |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(result));
  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && odd_req |=> illegal && !out_valid);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !flag_clr |=> ((flags | $past(flags)) == flags));
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (flags == 4'b0));
  p_nan_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && result[30:23] == 8'hFF && result[22:0] != '0
      |-> result[31:0] == 32'h7FC0_0000);
endmodule

bind bf16_fma_vec bfma_checker #(.VEC_W(VEC_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rd_idx(rd_idx),
  .rn_idx(rn_idx), .rm_idx(rm_idx), .flag_clr(flag_clr),
  .out_valid(out_valid), .result(result), .flags(flags), .illegal(illegal)
);

// File: tb/bf16_fma_vec_test.sv
module bf16_fma_vec_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, sel_top = 1'b0, flag_clr = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic [3:0]   rd_idx = '0, rn_idx = '0, rm_idx = '0;
  logic         out_valid, illegal;
  logic [127:0] result;
  logic [3:0]   flags;

  int n_cmp = 0, n_bad = 0;
  logic [127:0] exp_res = '0;
  logic [3:0]   exp_flags = '0;

  always #10 clk = ~clk;

  bf16_fma_vec uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel_top(sel_top),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .rd_idx(rd_idx),
    .rn_idx(rn_idx), .rm_idx(rm_idx), .flag_clr(flag_clr),
    .out_valid(out_valid), .result(result), .flags(flags), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // exact model: fixed point, LSB weight 2^-320
  function automatic logic [35:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                            input logic [31:0] c);
    logic [639:0] vp, vc, v, rem, half;
    logic [24:0]  mant;
    logic [15:0]  p;
    logic [31:0]  r;
    logic [3:0]   fl;
    int ea, eb, ec, k, ex, sh;
    bit sp, sc, sr, az, bz, cz, ai, bi, ci, an, bn, cn, snan, pinf, inv;
    ea = int'(a[14:7]); eb = int'(b[14:7]); ec = int'(c[30:23]);
    sp = a[15] ^ b[15]; sc = c[31];
    az = (ea == 0); bz = (eb == 0); cz = (ec == 0);
    an = (ea == 255) && (a[6:0] != 0);  ai = (ea == 255) && (a[6:0] == 0);
    bn = (eb == 255) && (b[6:0] != 0);  bi = (eb == 255) && (b[6:0] == 0);
    cn = (ec == 255) && (c[22:0] != 0); ci = (ec == 255) && (c[22:0] == 0);
    snan = (an && !a[6]) || (bn && !b[6]) || (cn && !c[22]);
    pinf = (ai || bi) && !(az || bz) && !an && !bn;
    inv  = snan || (ai && bz) || (bi && az) || (pinf && ci && (sp != sc));
    fl = 4'b0;
    if (an || bn || cn || inv) begin
      r = 32'h7FC0_0000; fl[3] = inv;
    end else if (pinf) r = {sp, 8'hFF, 23'h0};
    else if (ci) r = c;
    else if ((az || bz) && cz) r = {sp & sc, 31'h0};
    else if (az || bz) r = c;
    else begin
      p  = {1'b1, a[6:0]} * {1'b1, b[6:0]};
      vp = 640'(p) << (ea + eb + 52);
      vc = cz ? 640'd0 : (640'({1'b1, c[22:0]}) << (ec + 170));
      if (cz || sp == sc) begin v = vp + vc; sr = sp; end
      else if (vp >= vc) begin v = vp - vc; sr = sp; end
      else begin v = vc - vp; sr = sc; end
      if (v == 0) r = 32'h0;
      else begin
        k = -1;
        for (int i = 639; i >= 0; i--) if (v[i] && k < 0) k = i;
        ex = k - 193;
        if (ex < 1) begin r = {sr, 31'h0}; fl[1] = 1'b1; end
        else begin
          sh   = k - 23;
          mant = 25'(v >> sh);
          rem  = v & ((640'd1 << sh) - 1);
          half = 640'd1 << (sh - 1);
          if (rem > half || (rem == half && mant[0])) mant = mant + 1;
          if (mant[24]) begin mant = mant >> 1; ex = ex + 1; end
          if (ex >= 255) begin r = {sr, 8'hFF, 23'h0}; fl[2] = 1'b1; fl[0] = 1'b1; end
          else begin r = {sr, 8'(ex), mant[22:0]}; fl[0] = (rem != 0); end
        end
      end
    end
    return {fl, r};
  endfunction

  function automatic logic [131:0] ref_vec(input logic [127:0] a, input logic [127:0] b,
                                            input logic [127:0] c, input logic s);
    logic [131:0] o = '0;
    logic [35:0]  l;
    for (int e = 0; e < 4; e++) begin
      l = ref_lane(a[(2*e + int'(s))*16 +: 16], b[(2*e + int'(s))*16 +: 16], c[e*32 +: 32]);
      o[e*32 +: 32] = l[31:0];
      o[131:128]    = o[131:128] | l[35:32];
    end
    return o;
  endfunction

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                        input logic s, input logic [3:0] rd, input logic [3:0] rn,
                        input logic [3:0] rm, input string tag);
    logic [131:0] rv;
    logic ok;
    @(negedge clk);
    src_a = a; src_b = b; acc_in = c; sel_top = s;
    rd_idx = rd; rn_idx = rn; rm_idx = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ok = !(rd[0] | rn[0] | rm[0]);
    if (ok) begin
      rv = ref_vec(a, b, c, s);
      exp_res = rv[127:0];
      exp_flags = exp_flags | rv[131:128];
    end
    check({tag, " valid"}, 128'(out_valid), 128'(ok));
    check({tag, " illegal"}, 128'(illegal), 128'(!ok));
    check({tag, " result"}, result, exp_res);
    check({tag, " flags"}, 128'(flags), 128'(exp_flags));
  endtask

  function automatic logic [127:0] rep16(input logic [15:0] v);
    return {8{v}};
  endfunction
  function automatic logic [127:0] rep32(input logic [31:0] v);
    return {4{v}};
  endfunction

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    exp_flags = '0;
    check("R7 clear", 128'(flags), 128'(0));
  endtask

  task automatic t_reset();
    check("R9 reset result", result, '0);
    check("R9 reset flags", 128'(flags), 128'(0));
    check("R9 reset valid", 128'(out_valid), 128'(0));
    check("R9 reset illegal", 128'(illegal), 128'(0));
  endtask

  task automatic t_basic();
    run_op(rep16(16'h3F80), rep16(16'h3F80), rep32(32'h3F80_0000), 1'b0, 4'd0, 4'd2, 4'd4, "R2 one");
    check("R2 1*1+1 hand", result, rep32(32'h4000_0000));
  endtask

  task automatic t_select();
    logic [127:0] a = {4{16'h4040, 16'h4000}};
    run_op(a, rep16(16'h3F80), '0, 1'b0, 4'd2, 4'd2, 4'd2, "R1 bottom");
    check("R1 bottom hand", result, rep32(32'h4000_0000));
    run_op(a, rep16(16'h3F80), '0, 1'b1, 4'd2, 4'd2, 4'd2, "R1 top");
    check("R1 top hand", result, rep32(32'h4040_0000));
  endtask

  task automatic t_ties();
    run_op(rep16(16'h3980), rep16(16'h3980), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R2 tie down");
    check("R2 tie down hand", result, rep32(32'h3F80_0000));
    run_op(rep16(16'h3980), rep16(16'h3980), rep32(32'h3F80_0001), 1'b0, 0, 0, 0, "R2 tie up");
    check("R2 tie up hand", result, rep32(32'h3F80_0002));
    clear_flags();
  endtask

  task automatic t_cancel();
    run_op(rep16(16'h3FC0), rep16(16'h4000), rep32(32'hC040_0000), 1'b0, 0, 0, 0, "R3 cancel");
    check("R3 cancel hand", result, '0);
    run_op(rep16(16'hBFC0), rep16(16'h4000), rep32(32'h4040_0000), 1'b1, 0, 0, 0, "R3 cancel neg");
    check("R3 cancel neg hand", result, '0);
  endtask

  task automatic t_flush();
    run_op(rep16(16'h0040), rep16(16'h3F80), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R4 denorm in");
    check("R4 denorm in hand", result, rep32(32'h3F80_0000));
    run_op(rep16(16'h1C80), rep16(16'h9C80), '0, 1'b0, 0, 0, 0, "R4 tiny");
    check("R4 tiny hand", result, rep32(32'h8000_0000));
    check("R4 tiny unf only", 128'(flags), 128'(4'b0010));
    clear_flags();
  endtask

  task automatic t_special();
    run_op({rep16(16'h7F80)}, rep16(16'h0000), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R5 inf*0");
    check("R5 inf*0 hand", result, rep32(32'h7FC0_0000));
    clear_flags();
    run_op(rep16(16'h7F80), rep16(16'h3F80), rep32(32'hFF80_0000), 1'b0, 0, 0, 0, "R5 inf-inf");
    clear_flags();
    run_op(rep16(16'h7FC0), rep16(16'h3F80), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R5 qnan");
    check("R5 qnan no flag", 128'(flags), 128'(0));
    run_op(rep16(16'h3F80), rep16(16'h3F80), rep32(32'h7F80_0001), 1'b0, 0, 0, 0, "R5 snan acc");
    clear_flags();
    run_op(rep16(16'hFF80), rep16(16'h3F80), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R6 inf pass");
    check("R6 inf pass hand", result, rep32(32'hFF80_0000));
  endtask

  task automatic t_overflow();
    run_op(rep16(16'h7F00), rep16(16'hFF00), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R6 overflow");
    check("R6 overflow hand", result, rep32(32'hFF80_0000));
    check("R6 overflow flags", 128'(flags), 128'(4'b0101));
  endtask

  task automatic t_flags();
    logic [131:0] rv;
    @(negedge clk);
    src_a = rep16(16'h3980); src_b = rep16(16'h3980); acc_in = rep32(32'h3F80_0000);
    rd_idx = 0; rn_idx = 0; rm_idx = 0; in_valid = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    rv = ref_vec(src_a, src_b, acc_in, sel_top);
    exp_res = rv[127:0]; exp_flags = '0;
    check("R7 clear wins", 128'(flags), 128'(0));
    check("R7 clear op result", result, exp_res);
    run_op(rep16(16'h3F80), rep16(16'h3F80), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R7 exact keeps");
    run_op(rep16(16'h7F80), rep16(16'h0000), '0, 1'b0, 0, 0, 0, "R7 set inv");
    run_op(rep16(16'h3F80), rep16(16'h3F80), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R7 sticky");
    check("R7 sticky hand", 128'(flags), 128'(4'b1000));
    clear_flags();
  endtask

  task automatic t_illegal();
    run_op(rep16(16'h7F80), rep16(16'h0000), '0, 1'b0, 4'd1, 4'd0, 4'd0, "R8 odd rd");
    run_op(rep16(16'h7F80), rep16(16'h0000), '0, 1'b0, 4'd0, 4'd3, 4'd0, "R8 odd rn");
    run_op(rep16(16'h7F80), rep16(16'h0000), '0, 1'b0, 4'd0, 4'd0, 4'd9, "R8 odd rm");
    check("R8 flags untouched", 128'(flags), 128'(exp_flags));
  endtask

  task automatic t_hold();
    run_op(rep16(16'h4000), rep16(16'h4000), rep32(32'h3F80_0000), 1'b0, 0, 0, 0, "R9 op");
    @(negedge clk);
    check("R9 valid drops", 128'(out_valid), 128'(0));
    check("R9 result holds", result, exp_res);
  endtask

  task automatic t_random();
    logic [127:0] a, b, c;
    logic [15:0]  ae, be;
    int ep;
    for (int n = 0; n < 60; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      c = {$urandom, $urandom, $urandom, $urandom};
      if (n % 2 == 1) begin
        for (int e = 0; e < 4; e++) begin
          a[(2*e + n % 4 / 2)*16 + 7 +: 8] = 8'(100 + $urandom_range(0, 50));
          b[(2*e + n % 4 / 2)*16 + 7 +: 8] = 8'(100 + $urandom_range(0, 50));
          ae = a[(2*e + n % 4 / 2)*16 +: 16];
          be = b[(2*e + n % 4 / 2)*16 +: 16];
          ep = int'(ae[14:7]) + int'(be[14:7]) - 127 + $urandom_range(0, 1);
          c[e*32 + 23 +: 8] = 8'(ep);
          c[e*32 + 31]      = ~(ae[15] ^ be[15]);
          c[e*32 + 16 +: 7] = ae[6:0] ^ be[6:0];
        end
      end
      run_op(a, b, c, 1'(n % 4 / 2), 0, 0, 0, "R2 random");
    end
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_select();
    t_ties();
    t_cancel();
    t_flush();
    t_special();
    t_overflow();
    t_flags();
    t_illegal();
    t_hold();
    t_random();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule